// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block runs the hardware side of taking and leaving an exception handler on a small processor core. A priority arbiter offers a request that carries the winning exception number. When the core is in thread mode, the sequencer accepts the request and latches the core's eight-word architectural state frame. It then writes that frame to the stack through a stack port. In the same cycle it starts a read of the handler's vector from a vector-table port. When both transfers have completed, it switches to handler mode and reports the handler entry address, the active exception number and the new stack pointer.

When the handler signals that it has finished, the sequencer reads the frame back from the stack, hands it to the core and returns to thread mode. If the arbiter presents another request in the same cycle as the return, the sequencer tail-chains instead. It fetches only the new vector and enters the next handler. It leaves the stack untouched and the stack pointer unchanged. After reset, the first action is a read of table entry 0, which supplies the initial stack pointer.

Both memory ports use a valid/ready handshake. Every beat may be stalled for any number of cycles.

Top module: `exc_seq`

## Requirements
- R1: After reset, the first transfer is a vector-port read at `TABLE_BASE`. The word returned becomes `sp_out`, and then the block enters thread mode (`core_run`=1, `handler_mode`=0). No stack transfer occurs before thread mode.
- R2: A `take_req` seen in thread mode is accepted with `take_ack` in that cycle. It causes exactly 8 stack writes in strictly descending address order. Frame word k (`state_in[32k+31:32k]`) is written to address SP-32+4k, so word 7 goes first, to SP-4.
- R3: On acceptance, the vector read at address `TABLE_BASE + 4*take_num` is requested in the same cycle as the first stack write.
- R4: Handler mode is entered only once all 8 writes and the vector read have been accepted. At that point `handler_go` pulses for one cycle, `handler_pc` equals the vector word, `cur_exc` equals the accepted number and `sp_out` equals the old SP minus 32.
- R5: On both ports, a request that is not yet accepted (valid=1, ready=0) stays valid in the next cycle, with address, direction and write data unchanged. The sequence completes correctly under any pattern of wait cycles.
- R6: A `ret_req` in handler mode with no `take_req` causes 8 stack reads at strictly ascending addresses SP, SP+4, … SP+28. The word read from SP+4k is returned as frame word k. When the reads finish, `restore_valid` pulses for one cycle with `state_out` holding the frame, `sp_out` becomes SP+32 and the block returns to thread mode.
- R7: A `ret_req` together with `take_req` in handler mode is accepted with `take_ack` and tail-chains. The new vector at `TABLE_BASE + 4*take_num` is read, no stack transfer occurs, and then `handler_go` pulses with the new `handler_pc` and `cur_exc`. `sp_out` is unchanged.
- R8: In handler mode, a `take_req` without `ret_req` is not accepted. No `take_ack` appears, no port transfer starts and handler mode persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| take_req | input | 1 | Arbiter requests an exception entry |
| take_num | input | NUM_W | Winning exception number |
| take_ack | output | 1 | Request accepted this cycle |
| ret_req | input | 1 | Handler completion (one-cycle pulse in handler mode) |
| state_in | input | FRAME_WORDS*DW | Core state frame to save |
| state_out | output | FRAME_WORDS*DW | Restored state frame |
| restore_valid | output | 1 | One-cycle pulse: `state_out` is to be loaded |
| stk_valid | output | 1 | Stack request valid |
| stk_write | output | 1 | 1 = write, 0 = read |
| stk_addr | output | DW | Stack byte address |
| stk_wdata | output | DW | Stack write data |
| stk_ready | input | 1 | Stack port accepts the request |
| stk_rdata | input | DW | Stack read data, valid with `stk_ready` |
| vec_valid | output | 1 | Vector read request valid |
| vec_addr | output | DW | Vector-table byte address |
| vec_ready | input | 1 | Vector port accepts the request |
| vec_rdata | input | DW | Vector word, valid with `vec_ready` |
| handler_mode | output | 1 | Core is executing a handler |
| handler_go | output | 1 | One-cycle pulse on handler entry |
| handler_pc | output | DW | Handler entry address |
| cur_exc | output | NUM_W | Active exception number |
| sp_out | output | DW | Current stack pointer |
| core_run | output | 1 | Core may execute (thread or handler mode) |

## Verification
Entry is tried under four ready patterns: both ports always ready, random stalls on both, a slow vector port with a fast stack, and a slow stack with a fast vector port. Together these separate a sequencer that joins on both completions from one that enters on whichever finishes first. Every stack beat is matched in order against a scoreboard of addresses and data, which exposes errors in push order, pop order and frame word placement. A return with a simultaneous request is compared with a plain return, to show that the tail-chained path generates no stack beats and leaves the stack pointer unchanged. A request held during a handler, without a return, shows that it is not taken.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  typedef enum logic [2:0] {
    S_BOOT_GO,
    S_BOOT_WAIT,
    S_THREAD,
    S_ENTRY,
    S_HANDLER,
    S_TAIL,
    S_EXIT
  } seq_state_e;

endpackage

// File: rtl/exc_stack_eng.sv
module exc_stack_eng #(
  parameter int DW    = 32,
  parameter int WORDS = 8
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                push_i,
  input  logic [DW-1:0]       base_i,
  input  logic [WORDS*DW-1:0] frame_i,
  output logic                valid_o,
  output logic                write_o,
  output logic [DW-1:0]       addr_o,
  output logic [DW-1:0]       wdata_o,
  input  logic                ready_i,
  input  logic [DW-1:0]       rdata_i,
  output logic                done_o,
  output logic [WORDS*DW-1:0] frame_o
);

  localparam int CW = $clog2(WORDS);
  localparam logic [CW-1:0] LAST = CW'(WORDS - 1);
  localparam logic [DW-1:0] FRAME_BYTES = DW'(WORDS * 4);

  logic          act_q, act_d;
  logic          wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] base_q, base_d;
  logic          done_q, done_d;
  logic          beat;
  logic [CW-1:0] widx;
  logic [DW-1:0] frame_lo;
  logic [DW-1:0] word_q [WORDS];

  assign beat = act_q & ready_i;
  // Pushes walk the frame top-down, pops walk it bottom-up.
  assign widx = wr_q ? (LAST - cnt_q) : cnt_q;
  assign frame_lo = wr_q ? (base_q - FRAME_BYTES) : base_q;

  always_comb begin
    act_d  = act_q;
    wr_d   = wr_q;
    cnt_d  = cnt_q;
    base_d = base_q;
    done_d = 1'b0;
    if (start_i) begin
      act_d  = 1'b1;
      wr_d   = push_i;
      cnt_d  = '0;
      base_d = base_i;
    end else if (beat) begin
      if (cnt_q == LAST) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      cnt_q  <= cnt_d;
      base_q <= base_d;
      done_q <= done_d;
    end
  end

  // One holding register per frame word; loaded from the core on a push
  // start, or from the stack port on the matching pop beat.
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic          ld;
    logic [DW-1:0] nxt;
    assign ld  = (start_i & push_i) | (beat & ~wr_q & (cnt_q == CW'(g)));
    assign nxt = start_i ? frame_i[g*DW +: DW] : rdata_i;
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)  word_q[g] <= '0;
      else if (ld)  word_q[g] <= nxt;
    end
    assign frame_o[g*DW +: DW] = word_q[g];
  end

  assign valid_o = act_q;
  assign write_o = wr_q;
  assign addr_o  = frame_lo + (DW'(widx) << 2);
  assign wdata_o = word_q[widx];
  assign done_o  = done_q;

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(write_o) && $stable(wdata_o));

  p_push_desc_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    valid_o && ready_i && write_o && (cnt_q != LAST) |=> valid_o && (addr_o == $past(addr_o) - 4));

  p_pop_asc_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    valid_o && ready_i && !write_o && (cnt_q != LAST) |=> valid_o && (addr_o == $past(addr_o) + 4));

  p_start_idle_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    start_i |-> !valid_o);

endmodule

// File: rtl/exc_vec_eng.sv
module exc_vec_eng #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] addr_i,
  output logic          valid_o,
  output logic [DW-1:0] addr_o,
  input  logic          ready_i,
  input  logic [DW-1:0] rdata_i,
  output logic          done_o,
  output logic [DW-1:0] data_o
);

  logic          act_q, act_d;
  logic [DW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          done_q, done_d;

  always_comb begin
    act_d  = act_q;
    addr_d = addr_q;
    data_d = data_q;
    done_d = 1'b0;
    if (start_i) begin
      act_d  = 1'b1;
      addr_d = addr_i;
    end else if (act_q && ready_i) begin
      act_d  = 1'b0;
      data_d = rdata_i;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      addr_q <= addr_d;
      data_q <= data_d;
      done_q <= done_d;
    end
  end

  assign valid_o = act_q;
  assign addr_o  = addr_q;
  assign done_o  = done_q;
  assign data_o  = data_q;

  p_vec_hold_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(addr_o));

  p_vec_start_idle_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    start_i |-> !valid_o);

endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_seq_pkg::*;
#(
  parameter int              DW         = 32,
  parameter int              NUM_W      = 6,
  parameter int              WORDS      = 8,
  parameter logic [DW-1:0]   TABLE_BASE = '0
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             take_req_i,
  input  logic [NUM_W-1:0] take_num_i,
  input  logic             ret_req_i,
  output logic             take_ack_o,
  output logic             stk_start_o,
  output logic             stk_push_o,
  output logic [DW-1:0]    stk_base_o,
  input  logic             stk_busy_i,
  input  logic             stk_done_i,
  output logic             vec_start_o,
  output logic [DW-1:0]    vec_addr_o,
  input  logic             vec_busy_i,
  input  logic             vec_done_i,
  input  logic [DW-1:0]    vec_data_i,
  output logic             handler_mode_o,
  output logic             handler_go_o,
  output logic [DW-1:0]    handler_pc_o,
  output logic [NUM_W-1:0] cur_exc_o,
  output logic [DW-1:0]    sp_o,
  output logic             core_run_o,
  output logic             restore_o
);

  localparam logic [DW-1:0] FRAME_BYTES = DW'(WORDS * 4);

  seq_state_e       st_q, st_d;
  logic [DW-1:0]    sp_q, sp_d;
  logic [DW-1:0]    pc_q, pc_d;
  logic [NUM_W-1:0] cur_q, cur_d;
  logic [NUM_W-1:0] pend_q, pend_d;
  logic             sfin_q, sfin_d;
  logic             vfin_q, vfin_d;
  logic             go_q, go_d;
  logic             restore_q, restore_d;
  logic             accept_thread, accept_chain, accept_ret;
  logic [DW-1:0]    req_vec_addr;

  assign accept_thread = (st_q == S_THREAD) && take_req_i;
  assign accept_chain  = (st_q == S_HANDLER) && ret_req_i && take_req_i;
  assign accept_ret    = (st_q == S_HANDLER) && ret_req_i && !take_req_i;
  assign req_vec_addr  = TABLE_BASE + (DW'(take_num_i) << 2);

  // Port launches: both engines start in the acceptance cycle.
  always_comb begin
    take_ack_o  = accept_thread | accept_chain;
    stk_start_o = accept_thread | accept_ret;
    stk_push_o  = accept_thread;
    stk_base_o  = sp_q;
    vec_start_o = (st_q == S_BOOT_GO) | accept_thread | accept_chain;
    vec_addr_o  = (st_q == S_BOOT_GO) ? TABLE_BASE : req_vec_addr;
  end

  always_comb begin
    st_d      = st_q;
    sp_d      = sp_q;
    pc_d      = pc_q;
    cur_d     = cur_q;
    pend_d    = pend_q;
    sfin_d    = sfin_q;
    vfin_d    = vfin_q;
    go_d      = 1'b0;
    restore_d = 1'b0;
    unique case (st_q)
      S_BOOT_GO: st_d = S_BOOT_WAIT;
      S_BOOT_WAIT: begin
        if (vec_done_i) begin
          sp_d = vec_data_i;
          st_d = S_THREAD;
        end
      end
      S_THREAD: begin
        if (accept_thread) begin
          pend_d = take_num_i;
          sfin_d = 1'b0;
          vfin_d = 1'b0;
          st_d   = S_ENTRY;
        end
      end
      S_ENTRY: begin
        sfin_d = sfin_q | stk_done_i;
        vfin_d = vfin_q | vec_done_i;
        if (sfin_d && vfin_d) begin
          sp_d  = sp_q - FRAME_BYTES;
          pc_d  = vec_data_i;
          cur_d = pend_q;
          go_d  = 1'b1;
          st_d  = S_HANDLER;
        end
      end
      S_HANDLER: begin
        if (accept_chain) begin
          pend_d = take_num_i;
          st_d   = S_TAIL;
        end else if (accept_ret) begin
          st_d = S_EXIT;
        end
      end
      S_TAIL: begin
        if (vec_done_i) begin
          pc_d  = vec_data_i;
          cur_d = pend_q;
          go_d  = 1'b1;
          st_d  = S_HANDLER;
        end
      end
      S_EXIT: begin
        if (stk_done_i) begin
          sp_d      = sp_q + FRAME_BYTES;
          restore_d = 1'b1;
          st_d      = S_THREAD;
        end
      end
      default: st_d = S_BOOT_GO;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_BOOT_GO;
      sp_q      <= '0;
      pc_q      <= '0;
      cur_q     <= '0;
      pend_q    <= '0;
      sfin_q    <= 1'b0;
      vfin_q    <= 1'b0;
      go_q      <= 1'b0;
      restore_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      sp_q      <= sp_d;
      pc_q      <= pc_d;
      cur_q     <= cur_d;
      pend_q    <= pend_d;
      sfin_q    <= sfin_d;
      vfin_q    <= vfin_d;
      go_q      <= go_d;
      restore_q <= restore_d;
    end
  end

  assign handler_mode_o = (st_q == S_HANDLER);
  assign core_run_o     = (st_q == S_THREAD) || (st_q == S_HANDLER);
  assign handler_go_o   = go_q;
  assign handler_pc_o   = pc_q;
  assign cur_exc_o      = cur_q;
  assign sp_o           = sp_q;
  assign restore_o      = restore_q;

  p_boot_nostack_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == S_BOOT_WAIT) |-> !stk_busy_i);

  p_join_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    handler_go_o |-> handler_mode_o && !stk_busy_i && !vec_busy_i);

  p_restore_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == S_THREAD) && ($past(st_q) == S_EXIT) |-> restore_q);

  p_tail_quiet_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == S_TAIL) |-> !stk_busy_i);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == S_HANDLER) && !ret_req_i |=> !stk_busy_i && !vec_busy_i);

endmodule

// File: rtl/exc_seq.sv
module exc_seq #(
  parameter int            DW          = 32,
  parameter int            NUM_W       = 6,
  parameter int            FRAME_WORDS = 8,
  parameter logic [DW-1:0] TABLE_BASE  = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      take_req,
  input  logic [NUM_W-1:0]          take_num,
  output logic                      take_ack,
  input  logic                      ret_req,
  input  logic [FRAME_WORDS*DW-1:0] state_in,
  output logic [FRAME_WORDS*DW-1:0] state_out,
  output logic                      restore_valid,
  output logic                      stk_valid,
  output logic                      stk_write,
  output logic [DW-1:0]             stk_addr,
  output logic [DW-1:0]             stk_wdata,
  input  logic                      stk_ready,
  input  logic [DW-1:0]             stk_rdata,
  output logic                      vec_valid,
  output logic [DW-1:0]             vec_addr,
  input  logic                      vec_ready,
  input  logic [DW-1:0]             vec_rdata,
  output logic                      handler_mode,
  output logic                      handler_go,
  output logic [DW-1:0]             handler_pc,
  output logic [NUM_W-1:0]          cur_exc,
  output logic [DW-1:0]             sp_out,
  output logic                      core_run
);

  logic [1:0]    rs_q;
  logic          rst_ns;
  logic          stk_start, stk_push, stk_done;
  logic [DW-1:0] stk_base;
  logic          vec_start, vec_done;
  logic [DW-1:0] vec_start_addr, vec_data;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  exc_seq_ctrl #(
    .DW(DW), .NUM_W(NUM_W), .WORDS(FRAME_WORDS), .TABLE_BASE(TABLE_BASE)
  ) ctrl_i (
    .clk           (clk),
    .rst_ni        (rst_ns),
    .take_req_i    (take_req),
    .take_num_i    (take_num),
    .ret_req_i     (ret_req),
    .take_ack_o    (take_ack),
    .stk_start_o   (stk_start),
    .stk_push_o    (stk_push),
    .stk_base_o    (stk_base),
    .stk_busy_i    (stk_valid),
    .stk_done_i    (stk_done),
    .vec_start_o   (vec_start),
    .vec_addr_o    (vec_start_addr),
    .vec_busy_i    (vec_valid),
    .vec_done_i    (vec_done),
    .vec_data_i    (vec_data),
    .handler_mode_o(handler_mode),
    .handler_go_o  (handler_go),
    .handler_pc_o  (handler_pc),
    .cur_exc_o     (cur_exc),
    .sp_o          (sp_out),
    .core_run_o    (core_run),
    .restore_o     (restore_valid)
  );

  exc_stack_eng #(.DW(DW), .WORDS(FRAME_WORDS)) stk_i (
    .clk    (clk),
    .rst_ni (rst_ns),
    .start_i(stk_start),
    .push_i (stk_push),
    .base_i (stk_base),
    .frame_i(state_in),
    .valid_o(stk_valid),
    .write_o(stk_write),
    .addr_o (stk_addr),
    .wdata_o(stk_wdata),
    .ready_i(stk_ready),
    .rdata_i(stk_rdata),
    .done_o (stk_done),
    .frame_o(state_out)
  );

  exc_vec_eng #(.DW(DW)) vec_i (
    .clk    (clk),
    .rst_ni (rst_ns),
    .start_i(vec_start),
    .addr_i (vec_start_addr),
    .valid_o(vec_valid),
    .addr_o (vec_addr),
    .ready_i(vec_ready),
    .rdata_i(vec_rdata),
    .done_o (vec_done),
    .data_o (vec_data)
  );

endmodule

// File: tb/exc_seq_tb_top.sv
`timescale 1ns/1ps
module exc_seq_tb_top;

  localparam int          DW    = 32;
  localparam int          NUM_W = 6;
  localparam int          FW    = 8 * DW;
  localparam logic [31:0] BASE  = 32'h0000_0100;
  localparam logic [31:0] BOOT_SP = 32'h2000_0400;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             take_req = 1'b0;
  logic [NUM_W-1:0] take_num = '0;
  logic             take_ack;
  logic             ret_req = 1'b0;
  logic [FW-1:0]    state_in = '0;
  logic [FW-1:0]    state_out;
  logic             restore_valid;
  logic             stk_valid, stk_write;
  logic [DW-1:0]    stk_addr, stk_wdata;
  logic             stk_ready = 1'b0;
  logic [DW-1:0]    stk_rdata = '0;
  logic             vec_valid;
  logic [DW-1:0]    vec_addr;
  logic             vec_ready = 1'b0;
  logic [DW-1:0]    vec_rdata = '0;
  logic             handler_mode, handler_go;
  logic [DW-1:0]    handler_pc, sp_out;
  logic [NUM_W-1:0] cur_exc;
  logic             core_run;

  always #4 clk = ~clk;

  exc_seq #(.DW(DW), .NUM_W(NUM_W), .FRAME_WORDS(8), .TABLE_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .take_req(take_req), .take_num(take_num),
    .take_ack(take_ack), .ret_req(ret_req), .state_in(state_in),
    .state_out(state_out), .restore_valid(restore_valid),
    .stk_valid(stk_valid), .stk_write(stk_write), .stk_addr(stk_addr),
    .stk_wdata(stk_wdata), .stk_ready(stk_ready), .stk_rdata(stk_rdata),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .vec_ready(vec_ready),
    .vec_rdata(vec_rdata), .handler_mode(handler_mode), .handler_go(handler_go),
    .handler_pc(handler_pc), .cur_exc(cur_exc), .sp_out(sp_out), .core_run(core_run)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, mode = 0;
  int stk_beats = 0, vec_beats = 0;
  int first_stk = -1, first_vec = -1;
  bit finished = 1'b0;
  logic [DW-1:0] sp_model;
  logic [64:0] exp_q [$];
  logic [31:0] vexp_q [$];
  logic [31:0] mem [logic [31:0]];
  bit prev_stall = 1'b0;
  logic [DW-1:0] prev_addr = '0;

  function automatic logic [31:0] vec_word(input logic [31:0] a);
    return (a == BASE) ? BOOT_SP : (32'h0800_0001 + (a << 4));
  endfunction

  function automatic logic [FW-1:0] mk_frame(input logic [31:0] seed);
    logic [FW-1:0] f;
    for (int i = 0; i < 8; i++) f[i*32 +: 32] = seed + 32'(i) * 32'h0101_0001;
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Port responders: ready pattern and read data change on the falling edge.
  always @(negedge clk) begin
    case (mode)
      0: begin stk_ready = 1'b1; vec_ready = 1'b1; end
      1: begin stk_ready = 1'($urandom_range(0, 1)); vec_ready = 1'($urandom_range(0, 1)); end
      2: begin stk_ready = 1'b1; vec_ready = (cyc % 6 == 0); end
      default: begin stk_ready = (cyc % 3 == 0); vec_ready = 1'b1; end
    endcase
    stk_rdata = mem.exists(stk_addr) ? mem[stk_addr] : 32'hDEAD_0000;
    vec_rdata = vec_word(vec_addr);
  end

  // Monitor: scoreboard of port beats, stall stability, first-request cycles.
  always @(posedge clk) begin
    logic [64:0] e;
    logic [31:0] va;
    cyc++;
    if (rst_n) begin
      if (prev_stall)
        chk(stk_valid && (stk_addr == prev_addr), "R5 stack stall hold", {31'd0, stk_valid, stk_addr}, {32'd1, prev_addr});
      prev_stall = stk_valid && !stk_ready;
      prev_addr  = stk_addr;
      if (stk_valid && first_stk < 0) first_stk = cyc;
      if (vec_valid && first_vec < 0) first_vec = cyc;
      if (stk_valid && stk_ready) begin
        stk_beats++;
        if (stk_write) mem[stk_addr] = stk_wdata;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2/R6/R7 unexpected stack beat", {31'd0, stk_write, stk_addr}, 64'd0);
        end else begin
          e = exp_q.pop_front();
          chk((stk_write == e[64]) && (stk_addr == e[63:32]) && (!e[64] || stk_wdata == e[31:0]),
              e[64] ? "R2 push beat" : "R6 pop beat",
              {stk_write ? stk_wdata : 32'd0, stk_addr}, {e[64] ? e[31:0] : 32'd0, e[63:32]});
        end
      end
      if (vec_valid && vec_ready) begin
        vec_beats++;
        if (vexp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected vector read", {32'd0, vec_addr}, 64'd0);
        end else begin
          va = vexp_q.pop_front();
          chk(vec_addr == va, "R3 vector address", {32'd0, vec_addr}, {32'd0, va});
        end
      end
    end
  end

  task automatic wait_go();
    @(negedge clk);
    while (!handler_go) @(negedge clk);
  endtask

  task automatic take(input logic [NUM_W-1:0] num, input logic [FW-1:0] fr);
    for (int k = 0; k < 8; k++)
      exp_q.push_back({1'b1, sp_model - 32 + 32'(4 * (7 - k)), fr[(7 - k)*32 +: 32]});
    vexp_q.push_back(BASE + (32'(num) << 2));
    @(negedge clk);
    first_stk = -1;
    first_vec = -1;
    take_req = 1'b1;
    take_num = num;
    state_in = fr;
    #1;
    chk(take_ack, "R2 take_ack in thread mode", {63'd0, take_ack}, 64'd1);
    @(negedge clk);
    take_req = 1'b0;
    state_in = '0;
    wait_go();
    chk(first_stk == first_vec && first_stk > 0, "R3 vector read alongside first push",
        64'(first_vec), 64'(first_stk));
    chk(exp_q.size() == 0 && vexp_q.size() == 0, "R4 all beats done before handler",
        64'(exp_q.size() + vexp_q.size()), 64'd0);
    chk(handler_mode, "R4 handler_mode", {63'd0, handler_mode}, 64'd1);
    chk(handler_pc == vec_word(BASE + (32'(num) << 2)), "R4 handler_pc",
        {32'd0, handler_pc}, {32'd0, vec_word(BASE + (32'(num) << 2))});
    chk(cur_exc == num, "R4 cur_exc", 64'(cur_exc), 64'(num));
    sp_model = sp_model - 32;
    chk(sp_out == sp_model, "R4 sp after push", {32'd0, sp_out}, {32'd0, sp_model});
  endtask

  task automatic ret_plain(input logic [FW-1:0] fr);
    for (int k = 0; k < 8; k++) exp_q.push_back({1'b0, sp_model + 32'(4 * k), 32'd0});
    @(negedge clk);
    ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    while (!restore_valid) @(negedge clk);
    chk(exp_q.size() == 0, "R6 eight pops done", 64'(exp_q.size()), 64'd0);
    chk(state_out == fr, "R6 restored frame", state_out[63:0], fr[63:0]);
    chk(state_out[255:192] == fr[255:192], "R6 restored frame upper", state_out[255:192], fr[255:192]);
    sp_model = sp_model + 32;
    chk(sp_out == sp_model, "R6 sp after pop", {32'd0, sp_out}, {32'd0, sp_model});
    chk(core_run && !handler_mode, "R6 back in thread mode", {62'd0, core_run, handler_mode}, 64'd2);
  endtask

  task automatic ret_tail(input logic [NUM_W-1:0] num);
    int sb;
    vexp_q.push_back(BASE + (32'(num) << 2));
    sb = stk_beats;
    @(negedge clk);
    ret_req = 1'b1;
    take_req = 1'b1;
    take_num = num;
    #1;
    chk(take_ack, "R7 take_ack on chained return", {63'd0, take_ack}, 64'd1);
    @(negedge clk);
    ret_req = 1'b0;
    take_req = 1'b0;
    wait_go();
    chk(stk_beats == sb, "R7 no stack traffic when chaining", 64'(stk_beats), 64'(sb));
    chk(vexp_q.size() == 0, "R7 new vector read done", 64'(vexp_q.size()), 64'd0);
    chk(handler_pc == vec_word(BASE + (32'(num) << 2)) && cur_exc == num, "R7 new handler",
        {cur_exc, 26'd0, handler_pc}, {num, 26'd0, vec_word(BASE + (32'(num) << 2))});
    chk(sp_out == sp_model, "R7 sp unchanged", {32'd0, sp_out}, {32'd0, sp_model});
  endtask

  task automatic probe_hold();
    int sb, vb;
    sb = stk_beats;
    vb = vec_beats;
    @(negedge clk);
    take_req = 1'b1;
    take_num = 6'd20;
    for (int i = 0; i < 20; i++) begin
      #1;
      chk(!take_ack && handler_mode, "R8 request held off in handler", {62'd0, take_ack, handler_mode}, 64'd1);
      @(negedge clk);
    end
    take_req = 1'b0;
    chk(stk_beats == sb && vec_beats == vb && !stk_valid && !vec_valid, "R8 no port activity",
        64'(stk_beats + vec_beats), 64'(sb + vb));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'(cyc), 64'd0);
    finish_run();
  end

  initial begin
    vexp_q.push_back(BASE);
    repeat (4) @(negedge clk);
    chk(!core_run && !stk_valid && !vec_valid, "R1 quiet in reset", {61'd0, core_run, stk_valid, vec_valid}, 64'd0);
    rst_n = 1'b1;
    while (!core_run) @(negedge clk);
    chk(sp_out == BOOT_SP, "R1 initial sp from entry 0", {32'd0, sp_out}, {32'd0, BOOT_SP});
    chk(!handler_mode && stk_beats == 0 && vexp_q.size() == 0, "R1 thread mode, no stack beats",
        {63'd0, handler_mode}, 64'd0);
    sp_model = BOOT_SP;

    mode = 0;
    take(6'd5, mk_frame(32'hA000_0000));
    ret_plain(mk_frame(32'hA000_0000));

    mode = 2;
    take(6'd9, mk_frame(32'hB100_0000));
    ret_plain(mk_frame(32'hB100_0000));

    mode = 3;
    take(6'd11, mk_frame(32'hC200_0000));
    ret_tail(6'd3);
    probe_hold();
    ret_tail(6'd7);
    ret_plain(mk_frame(32'hC200_0000));

    mode = 1;
    take(6'd63, mk_frame(32'hD300_0000));
    ret_tail(6'd1);
    ret_plain(mk_frame(32'hD300_0000));
    take(6'd2, mk_frame(32'hE400_0000));
    ret_plain(mk_frame(32'hE400_0000));

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0 && vexp_q.size() == 0 && !stk_valid, "R6 idle after final return",
        64'(exp_q.size()), 64'd0);
    finish_run();
  end

endmodule